// File: doc/BRIEF.md
# Banked Memory Leaf Read Controller

This block serves one half of every cache-line read for a group of four DRAM banks. A read request carries a line address, and two address bits pick the bank. If that bank is enabled, the controller sends one command to the memory side. It then waits for the data to come back in two wide beats of 256 bits each, with 32 check bits alongside each beat. Each 64-bit word is checked and corrected on capture, so the buffer only ever holds clean or flagged words.

Once the whole half-line of 512 bits is held, the controller plays it out on the 128-bit system side in four beats, using a valid/ready handshake. Each output beat carries flags for the two words it contains. A self-test result port loads a per-bank disable mask. A request that hits a disabled bank does not reach memory and gets a single-beat error reply instead.

Both sides run on one clock. Each side has its own enable, which gates the transfers on that side.

Top module: `leaf_rd_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_ready` is 1 and `out_valid` and `mem_cmd_valid` are 0. All banks start enabled.
- R2: An accepted request to an enabled bank drives `mem_cmd_valid` high for exactly the next cycle. In that cycle `mem_cmd_addr` equals the request address, and `mem_cmd_bank` equals request address bits [8:7].
- R3: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` stays low from the accept until the last beat of the reply has been taken.
- R4: A request whose bank is disabled issues no memory command. In the next cycle it presents one beat with `out_err`=1, `out_last`=1, data all zero and both ECC flags 0.
- R5: A cycle with `bist_valid`=1 replaces the whole mask with `bist_fail`, where bit b set means bank b is disabled. When `bist_valid` is 0, `bist_fail` has no effect.
- R6: A memory beat is taken only in a cycle with `mem_rsp_valid`=1 and `mem_ce`=1. The first beat taken fills words 0 to 3 of the half-line and the second fills words 4 to 7. Word j of a beat is bits [64j+63:64j], and its check byte is `mem_rsp_ecc` bits [8j+7:8j].
- R7: The reply is four beats, lowest 128-bit slice first, so beat k carries words 2k and 2k+1. `out_last` is high on the fourth beat only. A beat advances only in a cycle with `out_valid`, `out_ready` and `bus_ce` all high, and the data holds steady while it waits.
- R8: Check byte layout: bit i (0 to 6) is the XOR of the positions, taken modulo the bit weight, of the data bits. Data bit 0 sits at code position 3, and the following data bits fill the later non-power-of-two positions in rising order. Equivalently, bits [6:0] equal the XOR of the code positions of all set data bits. Bit 7 is the even parity over the 64 data bits and check bits [6:0]. Any one flipped bit among the 72 is corrected, and `out_corr` is set on the beat that holds that word.
- R9: With two flipped bits in a word, `out_uncorr` is set on that word's beat, `out_corr` is not set by that word, and the received data is passed on unchanged.
- R10: Words with no error pass through unchanged, with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Line address of the read |
| bist_valid | input | 1 | Load the self-test result into the mask |
| bist_fail | input | 4 | Per-bank fault flags from self-test |
| mem_cmd_valid | output | 1 | One-cycle read command to memory |
| mem_cmd_addr | output | ADDR_W | Address of the issued read |
| mem_cmd_bank | output | 2 | Bank of the issued read |
| mem_ce | input | 1 | Memory-side transfer enable |
| mem_rsp_valid | input | 1 | Memory data beat present |
| mem_rsp_data | input | MEM_W | Memory data beat |
| mem_rsp_ecc | input | MEM_W/8 | Check bytes, one per 64-bit word |
| bus_ce | input | 1 | System-side transfer enable |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | BUS_W | Output beat data |
| out_last | output | 1 | Final beat of the reply |
| out_err | output | 1 | Reply for a disabled bank |
| out_corr | output | 1 | A word of this beat was corrected |
| out_uncorr | output | 1 | A word of this beat had a double error |

## Verification
The assertions assume that the memory side sends beats only after a command and sends exactly two per command. They also assume that the mask is not reloaded between an accept and its command. The bench keeps to both rules: it loads `bist_fail` only while the controller is idle, and it drives response beats only in the cycles after `mem_cmd_valid` was seen.

Outside those rules, the bench sends a beat with `mem_ce` low and stalls the output with `out_ready` or `bus_ce`. These cover the enable gating that the properties depend on. Every one of the 72 bit positions is flipped once across the sweep, and each double-error pattern uses two distinct bits.

// File: rtl/leaf_pkg.sv
package leaf_pkg;

    localparam int WORD_W = 64;
    localparam int CHK_W  = 8;
    localparam int HAM_W  = 7;
    localparam int CW_TOP = 71;   // highest single-error code position
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FILL,
        ST_DRAIN,
        ST_ERR
    } leaf_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              fixed;
        logic              bad;
    } word_res_t;

    // Spread data and check bits over code positions 1..CW_TOP.
    function automatic logic [CW_TOP:0] ham_place(input logic [WORD_W-1:0] d,
                                                  input logic [HAM_W-1:0]  c);
        logic [CW_TOP:0] cw;
        int k;
        int ci;
        cw = '0;
        k  = 0;
        ci = 0;
        for (int p = 1; p <= CW_TOP; p++) begin
            if ((p & (p - 1)) == 0) begin
                cw[p] = c[ci];
                ci++;
            end else begin
                cw[p] = d[k];
                k++;
            end
        end
        return cw;
    endfunction

    function automatic logic [WORD_W-1:0] ham_extract(input logic [CW_TOP:0] cw);
        logic [WORD_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW_TOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [HAM_W-1:0] ham_syndrome(input logic [CW_TOP:0] cw);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_TOP; p++) begin
            if (cw[p]) s = s ^ HAM_W'(p);
        end
        return s;
    endfunction

    function automatic word_res_t ecc_decode(input logic [WORD_W-1:0] d,
                                             input logic [CHK_W-1:0]  c);
        word_res_t        r;
        logic [CW_TOP:0]  cw;
        logic [HAM_W-1:0] s;
        logic             par;
        cw      = ham_place(d, c[HAM_W-1:0]);
        s       = ham_syndrome(cw);
        par     = (^d) ^ (^c);
        r.data  = d;
        r.fixed = 1'b0;
        r.bad   = 1'b0;
        if (par) begin
            if ((s & (s - HAM_W'(1))) == '0) begin
                r.fixed = 1'b1;            // a check bit or the parity bit flipped
            end else if (int'(s) <= CW_TOP) begin
                cw[s]   = ~cw[s];
                r.data  = ham_extract(cw);
                r.fixed = 1'b1;
            end else begin
                r.bad = 1'b1;
            end
        end else if (s != '0) begin
            r.bad = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/leaf_ecc_dec.sv
module leaf_ecc_dec
    import leaf_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [CHK_W-1:0]  chk_i,
    output word_res_t         res_o
);

    always_comb res_o = ecc_decode(word_i, chk_i);

endmodule

// File: rtl/leaf_bank_mask.sv
module leaf_bank_mask #(
    parameter  int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [NB-1:0] fail_i,
    input  logic [BW-1:0] sel_i,
    output logic          off_o,
    output logic [NB-1:0] mask_o
);

    logic [NB-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)         mask_q <= '0;
        else if (load_i) mask_q <= fail_i;
    end

    assign off_o  = mask_q[sel_i];
    assign mask_o = mask_q;

endmodule

// File: rtl/leaf_line_buf.sv
module leaf_line_buf
    import leaf_pkg::*;
#(
    parameter  int MEM_W    = 256,
    parameter  int BUS_W    = 128,
    parameter  int IN_BEATS = 2,
    localparam int WPB      = MEM_W / WORD_W,
    localparam int LINE_W   = MEM_W * IN_BEATS,
    localparam int NWORD    = LINE_W / WORD_W,
    localparam int OUTB     = LINE_W / BUS_W,
    localparam int WPO      = BUS_W / WORD_W,
    localparam int IN_IW    = (IN_BEATS > 1) ? $clog2(IN_BEATS) : 1,
    localparam int OUT_IW   = (OUTB > 1) ? $clog2(OUTB) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap_i,
    input  logic [IN_IW-1:0]       cap_idx_i,
    input  logic [MEM_W-1:0]       beat_data_i,
    input  logic [WPB*CHK_W-1:0]   beat_chk_i,
    input  logic [OUT_IW-1:0]      rd_idx_i,
    output logic [BUS_W-1:0]       rd_data_o,
    output logic                   rd_fixed_o,
    output logic                   rd_bad_o
);

    word_res_t         dec [WPB];
    logic [LINE_W-1:0] line_q;
    logic [NWORD-1:0]  fixed_q;
    logic [NWORD-1:0]  bad_q;

    for (genvar g = 0; g < WPB; g++) begin : g_dec
        leaf_ecc_dec u_dec (
            .word_i (beat_data_i[g*WORD_W +: WORD_W]),
            .chk_i  (beat_chk_i[g*CHK_W +: CHK_W]),
            .res_o  (dec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (cap_i) begin
            for (int g = 0; g < WPB; g++) begin
                line_q[(int'(cap_idx_i)*WPB + g)*WORD_W +: WORD_W] <= dec[g].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fixed_q <= '0;
            bad_q   <= '0;
        end else if (cap_i) begin
            for (int g = 0; g < WPB; g++) begin
                fixed_q[int'(cap_idx_i)*WPB + g] <= dec[g].fixed;
                bad_q[int'(cap_idx_i)*WPB + g]   <= dec[g].bad;
            end
        end
    end

    always_comb begin
        rd_data_o  = line_q[int'(rd_idx_i)*BUS_W +: BUS_W];
        rd_fixed_o = |fixed_q[int'(rd_idx_i)*WPO +: WPO];
        rd_bad_o   = |bad_q[int'(rd_idx_i)*WPO +: WPO];
    end

    // R9: a stored word is never both corrected and uncorrectable
    p_word_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        (fixed_q & bad_q) == '0);

endmodule

// File: rtl/leaf_rd_ctrl.sv
module leaf_rd_ctrl
    import leaf_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int MEM_W    = 256,
    parameter  int BUS_W    = 128,
    parameter  int IN_BEATS = 2,
    parameter  int BANK_LSB = 7,
    localparam int WPB      = MEM_W / WORD_W,
    localparam int ECC_W    = WPB * CHK_W,
    localparam int LINE_W   = MEM_W * IN_BEATS,
    localparam int OUTB     = LINE_W / BUS_W,
    localparam int IN_IW    = (IN_BEATS > 1) ? $clog2(IN_BEATS) : 1,
    localparam int OUT_IW   = (OUTB > 1) ? $clog2(OUTB) : 1,
    localparam int CNT_W    = (IN_IW > OUT_IW) ? IN_IW : OUT_IW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bist_valid,
    input  logic [NBANK-1:0]  bist_fail,
    output logic              mem_cmd_valid,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [BANK_W-1:0] mem_cmd_bank,
    input  logic              mem_ce,
    input  logic              mem_rsp_valid,
    input  logic [MEM_W-1:0]  mem_rsp_data,
    input  logic [ECC_W-1:0]  mem_rsp_ecc,
    input  logic              bus_ce,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_data,
    output logic              out_last,
    output logic              out_err,
    output logic              out_corr,
    output logic              out_uncorr
);

    leaf_state_e       state_q, state_d;
    logic [CNT_W-1:0]  beat_q, beat_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              bank_off;
    logic [NBANK-1:0]  bank_mask;
    logic              cap;
    logic              xfer;
    logic [BUS_W-1:0]  buf_data;
    logic              buf_fixed;
    logic              buf_bad;

    leaf_bank_mask #(.NB(NBANK)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .load_i (bist_valid),
        .fail_i (bist_fail),
        .sel_i  (req_addr[BANK_LSB +: BANK_W]),
        .off_o  (bank_off),
        .mask_o (bank_mask)
    );

    leaf_line_buf #(.MEM_W(MEM_W), .BUS_W(BUS_W), .IN_BEATS(IN_BEATS)) u_buf (
        .clk         (clk),
        .rst         (rst),
        .cap_i       (cap),
        .cap_idx_i   (beat_q[IN_IW-1:0]),
        .beat_data_i (mem_rsp_data),
        .beat_chk_i  (mem_rsp_ecc),
        .rd_idx_i    (beat_q[OUT_IW-1:0]),
        .rd_data_o   (buf_data),
        .rd_fixed_o  (buf_fixed),
        .rd_bad_o    (buf_bad)
    );

    assign cap  = (state_q == ST_FILL) && mem_rsp_valid && mem_ce;
    assign xfer = out_valid && out_ready && bus_ce;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        addr_d  = addr_q;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                addr_d  = req_addr;
                beat_d  = '0;
                state_d = bank_off ? ST_ERR : ST_ISSUE;
            end
            ST_ISSUE: state_d = ST_FILL;
            ST_FILL: if (cap) begin
                if (beat_q == CNT_W'(IN_BEATS - 1)) begin
                    beat_d  = '0;
                    state_d = ST_DRAIN;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_DRAIN: if (xfer) begin
                if (beat_q == CNT_W'(OUTB - 1)) begin
                    beat_d  = '0;
                    state_d = ST_IDLE;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_ERR: if (xfer) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_cmd_valid = (state_q == ST_ISSUE);
        mem_cmd_addr  = addr_q;
        mem_cmd_bank  = addr_q[BANK_LSB +: BANK_W];
        out_valid     = (state_q == ST_DRAIN) || (state_q == ST_ERR);
        out_err       = (state_q == ST_ERR);
        out_data      = (state_q == ST_DRAIN) ? buf_data : '0;
        out_corr      = (state_q == ST_DRAIN) && buf_fixed;
        out_uncorr    = (state_q == ST_DRAIN) && buf_bad;
        out_last      = (state_q == ST_ERR) ||
                        ((state_q == ST_DRAIN) && (beat_q == CNT_W'(OUTB - 1)));
    end

    // R3: an accepted request blocks the next one
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: a disabled bank gets an immediate error reply and no command
    p_off_bank_err_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && bank_off) |=> (out_valid && out_err && !mem_cmd_valid));

    // R4: commands only reach enabled banks
    p_cmd_bank_on_r4: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> !bank_mask[mem_cmd_bank]);

    // R7: a waiting beat holds its contents
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && bus_ce)) |=>
            (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_err)));

endmodule

// File: tb/leaf_rd_ctrl_bench.sv
`timescale 1ns/1ps
module leaf_rd_ctrl_bench;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [31:0]   req_addr;
    logic          bist_valid;
    logic [3:0]    bist_fail;
    logic          mem_cmd_valid;
    logic [31:0]   mem_cmd_addr;
    logic [1:0]    mem_cmd_bank;
    logic          mem_ce;
    logic          mem_rsp_valid;
    logic [255:0]  mem_rsp_data;
    logic [31:0]   mem_rsp_ecc;
    logic          bus_ce;
    logic          out_valid;
    logic          out_ready;
    logic [127:0]  out_data;
    logic          out_last;
    logic          out_err;
    logic          out_corr;
    logic          out_uncorr;

    always #2.5 clk = ~clk;

    leaf_rd_ctrl u_leaf_rd_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .bist_valid(bist_valid), .bist_fail(bist_fail),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_bank(mem_cmd_bank), .mem_ce(mem_ce), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_ecc(mem_rsp_ecc), .bus_ce(bus_ce),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_err(out_err), .out_corr(out_corr),
        .out_uncorr(out_uncorr)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [63:0] od [8];
    logic [63:0] sd [8];
    logic [63:0] ed [8];
    logic [7:0]  se [8];
    logic        ecor [8];
    logic        eunc [8];

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // check byte built by walking non-power-of-two positions from 3 upward
    function automatic logic [7:0] tb_ecc(input logic [63:0] d);
        logic [6:0] syn;
        int pos;
        syn = '0;
        pos = 2;
        for (int j = 0; j < 64; j++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[j]) syn = syn ^ 7'(pos);
        end
        return {(^d) ^ (^syn), syn};
    endfunction

    task automatic make_line(input int seed);
        for (int w = 0; w < 8; w++) begin
            od[w]   = 64'h9E37_79B9_7F4A_7C15 * 64'(seed * 8 + w + 1);
            sd[w]   = od[w];
            se[w]   = tb_ecc(od[w]);
            ed[w]   = od[w];
            ecor[w] = 1'b0;
            eunc[w] = 1'b0;
        end
    endtask

    task automatic flip(input int w, input int b);
        if (b < 64) sd[w][b] = ~sd[w][b];
        else        se[w][b-64] = ~se[w][b-64];
    endtask

    task automatic run_read(input logic [31:0] addr, input int stall, input string tag);
        @(negedge clk);
        check({tag, " R3 ready when idle"}, req_ready, 1);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 cmd valid"}, mem_cmd_valid, 1);
        check({tag, " R2 cmd bank"}, mem_cmd_bank, addr[8:7]);
        check({tag, " R2 cmd addr"}, mem_cmd_addr, addr);
        check({tag, " R3 busy after accept"}, req_ready, 0);
        @(negedge clk);
        if (stall == 1) begin   // R6: beat offered with mem_ce low must be ignored
            mem_rsp_valid = 1'b1;
            mem_ce        = 1'b0;
            mem_rsp_data  = ~{sd[3], sd[2], sd[1], sd[0]};
            mem_rsp_ecc   = ~{se[3], se[2], se[1], se[0]};
            @(negedge clk);
        end
        mem_ce        = 1'b1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = {sd[3], sd[2], sd[1], sd[0]};
        mem_rsp_ecc   = {se[3], se[2], se[1], se[0]};
        @(negedge clk);
        mem_rsp_data  = {sd[7], sd[6], sd[5], sd[4]};
        mem_rsp_ecc   = {se[7], se[6], se[5], se[4]};
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check($sformatf("%s R7 valid beat %0d", tag, k), out_valid, 1);
            check($sformatf("%s R6 R7 R10 data beat %0d", tag, k), out_data, {ed[2*k+1], ed[2*k]});
            check($sformatf("%s R8 corr beat %0d", tag, k), out_corr, ecor[2*k] | ecor[2*k+1]);
            check($sformatf("%s R9 uncorr beat %0d", tag, k), out_uncorr, eunc[2*k] | eunc[2*k+1]);
            check($sformatf("%s R7 last beat %0d", tag, k), out_last, (k == 3));
            check($sformatf("%s R4 no err beat %0d", tag, k), out_err, 0);
            if (k == 1 && stall == 1) begin
                out_ready = 1'b0;
                @(negedge clk);
                check({tag, " R7 hold on ready low"}, out_data, {ed[3], ed[2]});
                out_ready = 1'b1;
            end
            if (k == 2 && stall == 2) begin
                bus_ce = 1'b0;
                @(negedge clk);
                check({tag, " R7 hold on bus_ce low"}, out_data, {ed[5], ed[4]});
                check({tag, " R7 valid while held"}, out_valid, 1);
                bus_ce = 1'b1;
            end
            @(negedge clk);
        end
        check({tag, " R3 ready after drain"}, req_ready, 1);
        check({tag, " R7 idle after last"}, out_valid, 0);
    endtask

    task automatic run_err(input logic [31:0] addr, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R4 err valid"}, out_valid, 1);
        check({tag, " R4 err flag"}, out_err, 1);
        check({tag, " R4 err last"}, out_last, 1);
        check({tag, " R4 err data zero"}, out_data, 0);
        check({tag, " R4 err no flags"}, {out_corr, out_uncorr}, 0);
        check({tag, " R4 no cmd"}, mem_cmd_valid, 0);
        @(negedge clk);
        check({tag, " R4 no cmd after"}, mem_cmd_valid, 0);
        check({tag, " R4 done"}, out_valid, 0);
        check({tag, " R3 ready after err"}, req_ready, 1);
    endtask

    task automatic load_mask(input logic [3:0] m);
        @(negedge clk);
        bist_valid = 1'b1;
        bist_fail  = m;
        @(negedge clk);
        bist_valid = 1'b0;
    endtask

    function automatic logic [31:0] line_addr(input int n, input int bank);
        return (32'(n) << 9) | (32'(bank) << 7);
    endfunction

    initial begin
        rst           = 1'b1;
        req_valid     = 1'b0;
        req_addr      = '0;
        bist_valid    = 1'b0;
        bist_fail     = '0;
        mem_ce        = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_rsp_ecc   = '0;
        bus_ce        = 1'b1;
        out_ready     = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset ready", req_ready, 1);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset cmd", mem_cmd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset ready", req_ready, 1);
        check("R1 after reset out_valid", out_valid, 0);

        // R8: every one of the 72 bit positions flipped once
        for (int l = 0; l < 9; l++) begin
            make_line(l);
            for (int w = 0; w < 8; w++) begin
                flip(w, l * 8 + w);
                ecor[w] = 1'b1;
            end
            run_read(line_addr(l, l % 4), l % 3, $sformatf("single%0d", l));
        end

        make_line(20);
        run_read(line_addr(20, 2), 0, "clean R10");

        // R9: two distinct flipped bits per word
        for (int l = 0; l < 4; l++) begin
            make_line(30 + l);
            for (int w = 0; w < 8; w++) begin
                flip(w, (w * 9 + l) % 72);
                flip(w, (w * 9 + l + 31) % 72);
                eunc[w] = 1'b1;
                ed[w]   = sd[w];
            end
            run_read(line_addr(30 + l, l), l % 3, $sformatf("double%0d", l));
        end

        // per-beat flag grouping
        make_line(40);
        flip(0, 17);  ecor[0] = 1'b1;
        flip(3, 2);   flip(3, 66); eunc[3] = 1'b1; ed[3] = sd[3];
        flip(5, 71);  ecor[5] = 1'b1;
        run_read(line_addr(40, 3), 0, "mixed R8 R9");

        // R5 / R4: mask from self-test
        load_mask(4'b0101);
        run_err(line_addr(50, 0), "mask bank0 R5");
        make_line(51);
        run_read(line_addr(51, 1), 0, "mask bank1 R5");
        run_err(line_addr(52, 2), "mask bank2 R5");
        make_line(53);
        run_read(line_addr(53, 3), 2, "mask bank3 R5");

        @(negedge clk);
        bist_fail = 4'b1111;          // no load strobe: must be ignored
        repeat (3) @(negedge clk);
        make_line(54);
        run_read(line_addr(54, 1), 0, "no strobe R5");
        run_err(line_addr(55, 2), "still off R5");

        load_mask(4'b0000);
        make_line(56);
        run_read(line_addr(56, 0), 1, "reenabled R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule